// File: doc/BRIEF.md
# Trail Trace Byte Sequencer

This block stores a sixteen-byte path identification message and hands it to a framer one byte per frame, cycling through the message without end. Each pass over the sixteen bytes is a multiframe. The leading byte is the multiframe marker. Its top bit is set, and its lower seven bits hold a CRC-7 that the host computes over the previous pass. The block sends that value exactly as written and does no arithmetic on it. The other fifteen bytes usually hold printable characters of an access-point identifier, and each has its top bit clear.

The host writes bytes through a small address/data/strobe port into a shadow copy. The sequencer transmits from a separate active copy. The shadow moves into the active copy only at the edge where byte 15 goes out, so a multiframe never mixes old and new content. Every host write is checked against the marker rule. A sticky status output reports any byte position that currently holds content breaking that rule.

Top module: `tts_top`

## Requirements
- R1: After a synchronous reset, `trace_byte` is 0x00, `mf_start` is 0 and `marker_err` is 0. The slot index is 0, and the content sent first is 0x80 followed by fifteen bytes of 0x00.
- R2: On each cycle with `slot_stb` high, the next cycle shows on `trace_byte` the active byte at the current index, and the index then advances modulo 16. Bytes go out in the order 0,1,...,15,0,...
- R3: `mf_start` is 1 after a strobe that sent index 0 and 0 after a strobe that sent any other index. When `slot_stb` is low, `trace_byte`, `mf_start` and the slot index keep their values.
- R4: A host write changes only the shadow copy. The shadow replaces the active copy at the edge of the strobe that sends index 15. A write in that same cycle waits for the following boundary. New content therefore first appears at byte 0.
- R5: `marker_err` rises in the cycle after a write of bit 7 = 0 to address 0, or of bit 7 = 1 to any address from 1 to 15.
- R6: Each offending address stays flagged until the host writes a legal value to that same address. `marker_err` is the OR of all flags, so legal writes to other addresses leave it set.
- R7: Bytes are sent exactly as stored, including an illegal top bit and whatever bits 6..0 of byte 0 hold. No CRC is computed inside the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host byte address 0..15 |
| wr_data | input | 8 | Host write data |
| slot_stb | input | 1 | One-cycle pulse per frame trace slot |
| trace_byte | output | 8 | Byte sent in the last slot |
| mf_start | output | 1 | Last slot carried byte 0 |
| marker_err | output | 1 | Sticky marker rule violation |

## Verification
A wrong slot index shows on `trace_byte` and `mf_start` one cycle after the next strobe, as a byte out of place or a marker in the wrong slot. A wrong commit timing shows only at a multiframe boundary: a byte from a new message appears before byte 0, or old bytes persist a whole multiframe too long. A faulty error flag shows on `marker_err` in the cycle after the write, or on a later legal write that should or should not clear it.

// File: rtl/tts_pkg.sv
package tts_pkg;
    localparam int MSG_LEN = 16;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(MSG_LEN);
    localparam int LAST    = MSG_LEN - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef byte_t [MSG_LEN-1:0] msg_t;

    typedef struct packed {
        logic  valid;
        idx_t  addr;
        byte_t data;
    } host_wr_t;

    typedef struct packed {
        byte_t data;
        logic  first;
    } slot_out_t;

    // Marker rule: only position 0 carries a set top bit.
    function automatic logic marker_legal(idx_t a, byte_t d);
        return (a == idx_t'(0)) ? d[BYTE_W-1] : !d[BYTE_W-1];
    endfunction

    function automatic byte_t reset_byte(idx_t a);
        return (a == idx_t'(0)) ? byte_t'(1) << (BYTE_W - 1) : byte_t'(0);
    endfunction
endpackage

// File: rtl/tts_shadow_buf.sv
module tts_shadow_buf
    import tts_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  host_wr_t wr,
    output msg_t     shadow,
    output logic     any_err
);
    msg_t               sh_q;
    logic [MSG_LEN-1:0] err_q;

    generate
        for (genvar i = 0; i < MSG_LEN; i++) begin : g_pos
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_q[i]  <= reset_byte(idx_t'(i));
                    err_q[i] <= 1'b0;
                end else if (wr.valid && wr.addr == idx_t'(i)) begin
                    sh_q[i]  <= wr.data;
                    err_q[i] <= !marker_legal(idx_t'(i), wr.data);
                end
            end
        end
    endgenerate

    assign shadow  = sh_q;
    assign any_err = |err_q;
endmodule

// File: rtl/tts_slot_ctr.sv
module tts_slot_ctr
    import tts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output idx_t idx,
    output logic commit,
    output logic at_first
);
    idx_t idx_q;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (stb)
            idx_q <= (idx_q == idx_t'(LAST)) ? '0 : idx_q + idx_t'(1);
    end

    assign idx      = idx_q;
    assign commit   = stb && (idx_q == idx_t'(LAST));
    assign at_first = (idx_q == idx_t'(0));
endmodule

// File: rtl/tts_active_buf.sv
module tts_active_buf
    import tts_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  commit,
    input  msg_t  shadow,
    input  idx_t  rd_idx,
    output byte_t rd_byte
);
    msg_t act_q;

    generate
        for (genvar i = 0; i < MSG_LEN; i++) begin : g_pos
            always_ff @(posedge clk) begin
                if (rst)
                    act_q[i] <= reset_byte(idx_t'(i));
                else if (commit)
                    act_q[i] <= shadow[i];
            end
        end
    endgenerate

    assign rd_byte = act_q[rd_idx];
endmodule

// File: rtl/tts_top.sv
module tts_top
    import tts_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              slot_stb,
    output logic [BYTE_W-1:0] trace_byte,
    output logic              mf_start,
    output logic              marker_err
);
    host_wr_t  hw;
    msg_t      shadow;
    idx_t      idx;
    logic      commit;
    logic      at_first;
    byte_t     rd_byte;
    slot_out_t out_q;

    assign hw = '{valid: wr_en, addr: wr_addr, data: wr_data};

    tts_shadow_buf u_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr      (hw),
        .shadow  (shadow),
        .any_err (marker_err)
    );

    tts_slot_ctr u_ctr (
        .clk      (clk),
        .rst      (rst),
        .stb      (slot_stb),
        .idx      (idx),
        .commit   (commit),
        .at_first (at_first)
    );

    tts_active_buf u_active (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .shadow  (shadow),
        .rd_idx  (idx),
        .rd_byte (rd_byte)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_q <= '{data: '0, first: 1'b0};
        else if (slot_stb)
            out_q <= '{data: rd_byte, first: at_first};
    end

    assign trace_byte = out_q.data;
    assign mf_start   = out_q.first;
endmodule

// File: rtl/tts_checker.sv
module tts_checker
    import tts_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic              slot_stb,
    input logic [BYTE_W-1:0] trace_byte,
    input logic              mf_start,
    input logic              marker_err
);
    idx_t chk_cnt;
    logic bad_wr;

    always_ff @(posedge clk) begin
        if (rst)
            chk_cnt <= '0;
        else if (slot_stb)
            chk_cnt <= chk_cnt + idx_t'(1);
    end

    assign bad_wr = wr_en && !marker_legal(wr_addr, wr_data);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !slot_stb |=> $stable(trace_byte) && $stable(mf_start));

    assert_mfpos_R3: assert property (@(posedge clk) disable iff (rst)
        slot_stb |=> (mf_start == ($past(chk_cnt) == idx_t'(0))));

    assert_set_R5: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> marker_err);

    assert_norise_R6: assert property (@(posedge clk) disable iff (rst)
        !marker_err && !bad_wr |=> !marker_err);

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        marker_err && !wr_en |=> marker_err);
endmodule

bind tts_top tts_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .slot_stb   (slot_stb),
    .trace_byte (trace_byte),
    .mf_start   (mf_start),
    .marker_err (marker_err)
);

// File: tb/sim_tts_top.sv
module sim_tts_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       slot_stb = 1'b0;
    logic [7:0] trace_byte;
    logic       mf_start;
    logic       marker_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_act [16];
    logic [7:0] m_sh  [16];
    logic       m_err [16];
    int         m_idx;
    logic [7:0] m_out;
    logic       m_mf;

    always #10 clk = ~clk;

    tts_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .slot_stb(slot_stb), .trace_byte(trace_byte),
        .mf_start(mf_start), .marker_err(marker_err)
    );

    function automatic logic [6:0] crc7(input logic [7:0] msg [16]);
        logic [6:0] c = '0;
        for (int b = 0; b < 16; b++)
            for (int k = 7; k >= 0; k--) begin
                logic fb = c[6] ^ msg[b][k];
                c = {c[5:0], 1'b0};
                if (fb) c = c ^ 7'h09;
            end
        return c;
    endfunction

    function automatic logic m_any_err();
        logic e = 1'b0;
        for (int i = 0; i < 16; i++) e |= m_err[i];
        return e;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle from just after a negedge; check after the posedge.
    task automatic step(input logic stb, input logic we, input logic [3:0] a,
                        input logic [7:0] d, input string tag);
        slot_stb = stb; wr_en = we; wr_addr = a; wr_data = d;
        if (stb) begin
            m_out = m_act[m_idx];
            m_mf  = (m_idx == 0);
            if (m_idx == 15)
                for (int i = 0; i < 16; i++) m_act[i] = m_sh[i];
            m_idx = (m_idx + 1) % 16;
        end
        if (we) begin
            m_sh[a]  = d;
            m_err[a] = (a == 0) ? !d[7] : d[7];
        end
        @(posedge clk); #1;
        check({tag, " R2 R7"}, "trace_byte", trace_byte, m_out);
        check({tag, " R3"}, "mf_start", {7'b0, mf_start}, {7'b0, m_mf});
        check({tag, " R5 R6"}, "marker_err", {7'b0, marker_err}, {7'b0, m_any_err()});
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] msg [16];
        string id = "+44123456789012";
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            m_act[i] = (i == 0) ? 8'h80 : 8'h00;
            m_sh[i]  = m_act[i];
            m_err[i] = 1'b0;
        end
        m_idx = 0; m_out = 8'h00; m_mf = 1'b0;

        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state at the ports
        check("R1", "trace_byte", trace_byte, 8'h00);
        check("R1", "mf_start", {7'b0, mf_start}, 8'h00);
        check("R1", "marker_err", {7'b0, marker_err}, 8'h00);

        // R1: default message out of reset, back-to-back strobes
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, "R1");
        // R3: idle cycles hold outputs
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, "R3");

        // R4: load a legal message mid-multiframe
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R4");
        for (int i = 1; i < 16; i++) msg[i] = {1'b0, id[i-1][6:0]};
        for (int i = 0; i < 16; i++) msg[i == 0 ? 0 : i] = msg[i];
        msg[0] = {1'b1, crc7(m_act)};
        for (int i = 0; i < 16; i++) step(0, 1, 4'(i), msg[i], "R4");
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, "R4");

        // R4: write in the cycle of the index-15 strobe waits one more pass
        while (m_idx != 15) step(1, 0, 0, 0, "R4");
        step(1, 1, 4'd1, 8'h5A, "R4");
        for (int i = 0; i < 33; i++) step(1, 0, 0, 0, "R4");

        // R5, R6: sticky per-address marker errors
        step(0, 1, 4'd0, 8'h05, "R5");
        step(0, 1, 4'd5, 8'h41, "R6");
        step(0, 1, 4'd7, 8'hC1, "R5");
        step(0, 1, 4'd0, 8'h85, "R6");
        step(0, 0, 0, 0, "R6");
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, "R7");
        step(0, 1, 4'd7, 8'h41, "R6");
        step(0, 1, 4'd0, 8'h00, "R5");
        step(0, 1, 4'd0, 8'h81, "R6");

        // Constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            logic       s  = ($urandom_range(0, 9) < 6);
            logic       w  = ($urandom_range(0, 9) < 3);
            logic [3:0] a  = 4'($urandom_range(0, 15));
            logic [7:0] d;
            if (a == 0) d = {1'b1, crc7(m_act)};
            else        d = {1'b0, 7'($urandom_range(32, 126))};
            if ($urandom_range(0, 19) == 0) d[7] = ~d[7];
            step(s, w, a, d, "RND");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule